// File: doc/BRIEF.md
# Virtual-Machine Integer ALU

This block executes a single arithmetic instruction of a register-based 64-bit virtual machine. A decode stage hands it the 8-bit opcode, the current value of the destination register, the value of the source register and the 32-bit immediate, and raises `start_i` for one cycle. The block answers with a one-cycle `done_o` strobe. In the same cycle it presents the value to write back on `result_o`, qualified by `wr_en_o`, or it raises `illegal_o` when the instruction cannot be executed.

The opcode carries two arithmetic classes, a 32-bit one and a 64-bit one, together with a source-select bit and a 4-bit operation. Most operations finish one cycle after the strobe. Unsigned divide and modulo run on a bit-serial divider and hold `busy_o` high while it works. A strobe that arrives while `busy_o` is high is dropped. The byte-order conversion works on the destination value only and assumes a little-endian host.

Top module: `vm_alu`

## Requirements
- R1: Opcode bits [2:0] pick the class: 3'b100 is the 32-bit class and 3'b111 is the 64-bit class. Bit 3 picks the second operand: 1 takes `src_i`, 0 takes the immediate. Bits [7:4] pick the operation.
- R2: Operation codes in bits [7:4] are 0 add, 1 sub, 2 mul, 4 or, 5 and and 0xA xor; they wrap modulo 2^width. Code 0xB is move, which returns the second operand.
- R3: In the 32-bit class only the low 32 bits of each operand are used, and result bits [63:32] are zero. Byte conversion (R10, R11) is the one exception.
- R4: In the 64-bit class the immediate is sign-extended to 64 bits. In the 32-bit class it is zero-extended. Divide and modulo then treat the operand as unsigned.
- R5: Shifts use code 6 for left, 7 for logical right and 0xC for arithmetic right. The shift amount is the second operand masked to 6 bits in the 64-bit class and to 5 bits in the 32-bit class. Arithmetic right shift fills with the operand's sign bit, which is bit 63 or bit 31.
- R6: Code 8 returns the bitwise complement of the second operand.
- R7: Code 3 (unsigned divide) and code 9 (unsigned modulo) with a nonzero divisor raise `busy_o` from the cycle after the strobe until the cycle in which `done_o` rises. They take more than one cycle.
- R8: A divide by a zero divisor returns 0 one cycle after the strobe.
- R9: A modulo by a zero divisor returns the destination unchanged in the 64-bit class. In the 32-bit class it returns the low 32 bits of the destination, zero-extended. Either way the result comes one cycle after the strobe.
- R10: Code 0xD in the 32-bit class with opcode bit 3 = 0 is a little-endian conversion. An immediate of 16 or 32 zero-extends the low 16 or 32 bits, and an immediate of 64 returns the destination unchanged.
- R11: Code 0xD in the 32-bit class with opcode bit 3 = 1 is a big-endian conversion. It reverses the byte order within the low 16, 32 or 64 bits and zeroes every bit above that width.
- R12: The instruction is illegal in four cases: a class other than 3'b100 or 3'b111, a code above 0xD, code 0xD in the 64-bit class, or code 0xD with an immediate other than 16, 32 or 64. An illegal instruction gives `done_o` with `illegal_o`=1, `wr_en_o`=0 and `result_o`=0.
- R13: After reset all outputs are 0. Every operation other than a divide or modulo with a nonzero divisor gives `done_o` exactly one cycle after the accepted strobe. `done_o` lasts one cycle per instruction, and `wr_en_o` and `illegal_o` are high only together with `done_o`.
- R14: A `start_i` pulse while `busy_o` is high is ignored: it produces no `done_o` and leaves the running division's result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin executing the presented instruction |
| opcode_i | input | 8 | Instruction opcode |
| dst_i | input | 64 | Destination register value |
| src_i | input | 64 | Source register value |
| imm_i | input | 32 | Instruction immediate |
| busy_o | output | 1 | Divider running; new strobes dropped |
| done_o | output | 1 | One-cycle completion strobe |
| wr_en_o | output | 1 | Write `result_o` back to the destination |
| illegal_o | output | 1 | Instruction could not be executed |
| result_o | output | 64 | Value to write back |

## Verification
The hardest case to reach is a second strobe that lands while the divider is in the middle of its iterations. The bench starts a 64-bit divide and, once `busy_o` is visible, drives an add strobe for one cycle. The scoreboard then holds only the division's expected item, so any extra completion or a corrupted quotient is reported. The bench also aims at operands where the two classes give different results. These include a 32-bit divide whose destination has nonzero upper bits, an all-ones 64-bit immediate used as a divisor, and shift counts above the mask width.

// File: rtl/vm_alu.sv
module vm_alu #(
  parameter int XW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [7:0]    opcode_i,
  input  logic [XW-1:0] dst_i,
  input  logic [XW-1:0] src_i,
  input  logic [31:0]   imm_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          wr_en_o,
  output logic          illegal_o,
  output logic [XW-1:0] result_o
);
  localparam int HW = XW / 2;
  localparam int NB = XW / 8;
  localparam int SW = $clog2(XW);
  localparam int CW = $clog2(XW + 1);
  localparam logic [3:0] OP_DIV = 4'h3, OP_MOD = 4'h9, OP_END = 4'hD;

  wire [2:0] cls    = opcode_i[2:0];
  wire       wide   = (cls == 3'd7);
  wire       cls_ok = wide || (cls == 3'd4);
  wire       sel_r  = opcode_i[3];
  wire [3:0] op     = opcode_i[7:4];

  wire [XW-1:0] imm_x = wide ? {{(XW-32){imm_i[31]}}, imm_i} : {{(XW-32){1'b0}}, imm_i};
  wire [XW-1:0] b_raw = sel_r ? src_i : imm_x;
  wire [XW-1:0] a     = wide ? dst_i : {{HW{1'b0}}, dst_i[HW-1:0]};
  wire [XW-1:0] b     = wide ? b_raw : {{HW{1'b0}}, b_raw[HW-1:0]};
  wire [SW-1:0] sh    = wide ? b[SW-1:0] : {1'b0, b[SW-2:0]};

  wire w16 = (imm_i == 32'd16);
  wire w32 = (imm_i == 32'd32);
  wire w64 = (imm_i == 32'd64);
  wire end_ok  = !wide && (w16 || w32 || w64);
  wire legal   = cls_ok && (op <= OP_END) && (op != OP_END || end_ok);
  wire div_op  = (op == OP_DIV) || (op == OP_MOD);
  wire b_zero  = (b == '0);

  logic [XW-1:0] rev;
  always_comb
    for (int i = 0; i < NB; i++) rev[8*i +: 8] = dst_i[8*(NB-1-i) +: 8];

  logic [XW-1:0] swapped;
  always_comb begin
    if (!sel_r)
      swapped = w16 ? {{(XW-16){1'b0}}, dst_i[15:0]} :
                w32 ? {{(XW-32){1'b0}}, dst_i[31:0]} : dst_i;
    else
      swapped = w16 ? {{(XW-16){1'b0}}, rev[XW-1 -: 16]} :
                w32 ? {{(XW-32){1'b0}}, rev[XW-1 -: 32]} : rev;
  end

  logic [HW-1:0] sar_n;
  logic [XW-1:0] sar_w, raw, alu_res;
  assign sar_n = $signed(a[HW-1:0]) >>> sh[SW-2:0];
  assign sar_w = $signed(a) >>> sh;

  always_comb begin
    case (op)
      4'h0:    raw = a + b;
      4'h1:    raw = a - b;
      4'h2:    raw = a * b;
      4'h4:    raw = a | b;
      4'h5:    raw = a & b;
      4'h6:    raw = a << sh;
      4'h7:    raw = a >> sh;
      4'h8:    raw = ~b;
      4'hA:    raw = a ^ b;
      4'hB:    raw = b;
      4'hC:    raw = wide ? sar_w : {{HW{1'b0}}, sar_n};
      default: raw = '0;
    endcase
    if (op == OP_END)  alu_res = swapped;
    else if (wide)     alu_res = raw;
    else               alu_res = {{HW{1'b0}}, raw[HW-1:0]};
  end

  typedef enum logic {S_IDLE, S_DIV} st_t;
  st_t st;
  logic [XW-1:0] quo, rem, dvs;
  logic [CW-1:0] cnt;
  logic          is_mod;

  wire [XW:0]   rem_sh = {rem, quo[XW-1]};
  wire          fits   = rem_sh >= {1'b0, dvs};
  wire [XW:0]   diff   = rem_sh - {1'b0, dvs};
  wire [XW-1:0] rem_nx = fits ? diff[XW-1:0] : rem_sh[XW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; quo <= '0; rem <= '0; dvs <= '0; cnt <= '0; is_mod <= 1'b0;
      done_o <= 1'b0; wr_en_o <= 1'b0; illegal_o <= 1'b0; result_o <= '0;
    end else begin
      done_o <= 1'b0; wr_en_o <= 1'b0; illegal_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          if (!legal) begin
            done_o <= 1'b1; illegal_o <= 1'b1; result_o <= '0;
          end else if (div_op && !b_zero) begin
            st     <= S_DIV;
            quo    <= wide ? a : {a[HW-1:0], {HW{1'b0}}};
            rem    <= '0;
            dvs    <= b;
            cnt    <= wide ? CW'(XW) : CW'(HW);
            is_mod <= (op == OP_MOD);
          end else begin
            done_o   <= 1'b1;
            wr_en_o  <= 1'b1;
            result_o <= div_op ? ((op == OP_MOD) ? a : '0) : alu_res;
          end
        end
        S_DIV: if (cnt == '0) begin
          st <= S_IDLE; done_o <= 1'b1; wr_en_o <= 1'b1;
          result_o <= is_mod ? rem : quo;
        end else begin
          rem <= rem_nx;
          quo <= {quo[XW-2:0], fits};
          cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (st == S_DIV);
endmodule

// File: rtl/vm_alu_chk.sv
module vm_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [7:0]  opcode_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        wr_en_o,
  input logic        illegal_o,
  input logic [63:0] result_o
);
  logic narrow_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) narrow_q <= 1'b0;
    else if (start_i && !busy_o)
      narrow_q <= (opcode_i[2:0] == 3'd4) && (opcode_i[7:4] != 4'hD);

  // R13
  single_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && opcode_i[7:4] != 4'h3 && opcode_i[7:4] != 4'h9 |=> done_o);
  // R7
  div_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && (opcode_i[2:0] == 3'd4 || opcode_i[2:0] == 3'd7) &&
    (opcode_i[7:4] == 4'h3 || opcode_i[7:4] == 4'h9) |=> (busy_o || done_o));
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));
  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));
  // R12
  wr_ill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_o && illegal_o));
  // R13
  flags_need_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o || illegal_o) |-> done_o);
  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && wr_en_o && narrow_q |-> result_o[63:32] == 32'd0);
endmodule

bind vm_alu vm_alu_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
  .busy_o(busy_o), .done_o(done_o), .wr_en_o(wr_en_o),
  .illegal_o(illegal_o), .result_o(result_o)
);

// File: tb/vm_alu_tb_top.sv
`timescale 1ns/1ps
module vm_alu_tb_top;
  logic clk = 0, rst_n = 0, start_i = 0;
  logic [7:0]  opcode_i = 0;
  logic [63:0] dst_i = 0, src_i = 0;
  logic [31:0] imm_i = 0;
  logic busy_o, done_o, wr_en_o, illegal_o;
  logic [63:0] result_o;

  vm_alu dut_i (.*);

  always #10 clk = ~clk;

  typedef struct {
    logic [63:0] r; logic w; logic il; logic one; int t0; string tag;
  } exp_t;
  exp_t sb[$];
  int n_run = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void model(input logic [7:0] opc, input logic [63:0] d, s,
      input logic [31:0] im, output logic [63:0] r, output logic w,
      output logic il, output logic one);
    logic wide, narrow; logic [63:0] sv, x, y; int nb;
    wide = opc[2:0] == 3'd7; narrow = opc[2:0] == 3'd4;
    sv = opc[3] ? s : (wide ? {{32{im[31]}}, im} : {32'd0, im});
    x = wide ? d : d & 64'hFFFF_FFFF; y = wide ? sv : sv & 64'hFFFF_FFFF;
    r = 0; w = 1; il = 0; one = 1;
    if (!(wide || narrow) || opc[7:4] > 4'hD ||
        (opc[7:4] == 4'hD && (wide || !(im == 16 || im == 32 || im == 64)))) begin
      w = 0; il = 1; return;
    end
    case (opc[7:4])
      4'h0: r = x + y;   4'h1: r = x - y;   4'h2: r = x * y;
      4'h3: begin r = (y == 0) ? 64'd0 : x / y; one = (y == 0); end
      4'h4: r = x | y;   4'h5: r = x & y;
      4'h6: r = x << (wide ? y[5:0] : y[4:0]);
      4'h7: r = x >> (wide ? y[5:0] : y[4:0]);
      4'h8: r = ~y;
      4'h9: begin r = (y == 0) ? x : x % y; one = (y == 0); end
      4'hA: r = x ^ y;   4'hB: r = y;
      4'hC: r = wide ? 64'($signed(x) >>> y[5:0])
                     : {32'd0, 32'($signed(x[31:0]) >>> y[4:0])};
      default: begin
        nb = im / 8;
        for (int k = 0; k < nb; k++)
          r[8*k +: 8] = opc[3] ? d[8*(nb-1-k) +: 8] : d[8*k +: 8];
      end
    endcase
    if (!wide && opc[7:4] != 4'hD) r = r & 64'hFFFF_FFFF;
  endfunction

  always @(negedge clk) begin
    if (rst_n && done_o) begin
      exp_t e;
      n_run++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R14 unexpected done: actual result=%h expected no completion", result_o);
      end else begin
        e = sb.pop_front();
        if (result_o !== e.r || wr_en_o !== e.w || illegal_o !== e.il) begin
          n_fail++;
          $display("FAIL %s: actual r=%h w=%b il=%b expected r=%h w=%b il=%b",
                   e.tag, result_o, wr_en_o, illegal_o, e.r, e.w, e.il);
        end
        n_run++;
        if (e.one && cyc - e.t0 != 1) begin
          n_fail++;
          $display("FAIL R13 latency %s: actual %0d expected 1", e.tag, cyc - e.t0);
        end else if (!e.one && cyc - e.t0 < 3) begin
          n_fail++;
          $display("FAIL R7 latency %s: actual %0d expected >2", e.tag, cyc - e.t0);
        end
      end
    end
  end

  task automatic issue(input string tag, input logic [7:0] opc,
      input logic [63:0] d, s, input logic [31:0] im);
    exp_t e;
    model(opc, d, s, im, e.r, e.w, e.il, e.one);
    e.tag = tag;
    @(negedge clk);
    opcode_i = opc; dst_i = d; src_i = s; imm_i = im; start_i = 1;
    e.t0 = cyc;
    sb.push_back(e);
    @(negedge clk);
    start_i = 0;
    if (!e.one) begin
      n_run++;
      if (busy_o !== 1'b1) begin
        n_fail++;
        $display("FAIL R7 busy %s: actual %b expected 1", tag, busy_o);
      end
    end
    while (sb.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    n_run++;
    if ({done_o, busy_o, wr_en_o, illegal_o} !== 4'b0 || result_o !== 64'd0) begin
      n_fail++;
      $display("FAIL R13 reset: actual d/b/w/i=%b%b%b%b r=%h expected all 0",
               done_o, busy_o, wr_en_o, illegal_o, result_o);
    end

    issue("R2 add64 wrap",      8'h0F, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 0);
    issue("R1 R3 add32 imm",    8'h04, 64'h1_FFFF_FFFF, 0, 32'd1);
    issue("R2 sub64 reg",       8'h1F, 64'd3, 64'd5, 0);
    issue("R2 mul64",           8'h2F, 64'h1_0000_0001, 64'h1_0000_0003, 0);
    issue("R3 mul32",           8'h2C, 64'hAB_0001_0000, 64'h77_0001_0000, 0);
    issue("R2 or/and/xor",      8'h5F, 64'hF0F0, 64'h3C3C, 0);
    issue("R2 xor32 imm",       8'hA4, 64'hFFFF_0000_1234_5678, 0, 32'hFFFF_FFFF);
    issue("R4 mov64 imm sext",  8'hB7, 0, 0, 32'h8000_0000);
    issue("R4 mov32 imm zext",  8'hB4, 64'h55, 0, 32'h8000_0000);
    issue("R3 mov32 reg",       8'hBC, 0, 64'hDEAD_BEEF_CAFE_F00D, 0);
    issue("R5 lsh64 mask",      8'h6F, 64'h1, 64'd65, 0);
    issue("R5 lsh32 mask",      8'h64, 64'h8000_0001, 0, 32'd33);
    issue("R5 rsh64",           8'h77, 64'h8000_0000_0000_0000, 0, 32'd63);
    issue("R5 arsh64",          8'hCF, 64'h8000_0000_0000_0000, 64'd4, 0);
    issue("R5 arsh32",          8'hC4, 64'hFFFF_FFFF_8000_0000, 0, 32'd36);
    issue("R6 neg64",           8'h8F, 64'd9, 64'h0F, 0);
    issue("R6 neg32 imm",       8'h84, 64'd9, 0, 32'h0000_00FF);
    issue("R7 div64",           8'h3F, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 0);
    issue("R7 mod64",           8'h9F, 64'd100, 64'd7, 0);
    issue("R7 R3 div32 upper",  8'h34, 64'hABCD_0000_0000_0064, 0, 32'd7);
    issue("R7 mod32 reg",       8'h9C, 64'h1_FFFF_FFFF, 64'h1_0000_0010, 0);
    issue("R4 div64 imm -1",    8'h37, 64'd10, 0, 32'hFFFF_FFFF);
    issue("R4 mod64 imm -1",    8'h97, 64'd10, 0, 32'hFFFF_FFFF);
    issue("R8 div64 by zero",   8'h3F, 64'd77, 64'd0, 0);
    issue("R8 div32 by zero",   8'h3C, 64'd77, 64'h5_0000_0000, 0);
    issue("R9 mod64 by zero",   8'h9F, 64'hFEED_0000_0000_0042, 64'd0, 0);
    issue("R9 mod32 by zero",   8'h94, 64'hFEED_0000_0000_0042, 0, 0);
    issue("R10 le16",           8'hD4, 64'h1122_3344_5566_7788, 0, 32'd16);
    issue("R10 le32",           8'hD4, 64'h1122_3344_5566_7788, 0, 32'd32);
    issue("R10 le64",           8'hD4, 64'h1122_3344_5566_7788, 0, 32'd64);
    issue("R11 be16",           8'hDC, 64'h1122_3344_5566_7788, 0, 32'd16);
    issue("R11 be32",           8'hDC, 64'h1122_3344_5566_7788, 0, 32'd32);
    issue("R11 be64",           8'hDC, 64'h1122_3344_5566_7788, 0, 32'd64);
    issue("R12 end width 8",    8'hDC, 64'h1234, 0, 32'd8);
    issue("R12 end class64",    8'hD7, 64'h1234, 0, 32'd16);
    issue("R12 code 0xE",       8'hE4, 64'h1234, 64'd1, 0);
    issue("R12 bad class",      8'h0D, 64'h1234, 64'd1, 0);

    begin : r14_busy_ignore
      exp_t e;
      model(8'h3F, 64'd1000, 64'd10, 0, e.r, e.w, e.il, e.one);
      e.tag = "R14 div under extra start";
      @(negedge clk);
      opcode_i = 8'h3F; dst_i = 64'd1000; src_i = 64'd10; start_i = 1;
      e.t0 = cyc;
      sb.push_back(e);
      @(negedge clk);
      opcode_i = 8'h0F; dst_i = 64'd1; src_i = 64'd1;
      @(negedge clk);
      start_i = 0;
      while (sb.size() != 0) @(posedge clk);
      repeat (4) @(negedge clk);
      n_run++;
      if (sb.size() != 0 || done_o !== 1'b0) begin
        n_fail++;
        $display("FAIL R14 after ignore: actual done=%b expected 0", done_o);
      end
    end

    issue("R13 back-to-back",   8'h07, 64'd40, 0, 32'd2);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule